// File: doc/BRIEF.md
# Load Step Detector and Filter Refresh Sequencer

This block sits next to a two-stage averaging filter that smooths a stream of raw converter samples. On each valid sample it compares the raw value with the current filter output. When the gap is larger than a programmable threshold on two valid samples in a row, it treats this as a real change of load rather than a glitch. It then tells the second filter stage to load every entry of its window with the newest sample.

After a change is declared, the block enters a refresh phase that lasts six valid samples. On each of those samples it tells the averaging window to overwrite its contents with the newest sample, so the output follows the load cell while it settles. Step detection is off for the whole refresh phase. Normal averaging resumes when the phase ends. The filters and any display logic are outside the block.

Top module: `step_detect`

## Requirements
- R1: A valid sample "exceeds" when the absolute difference between the sample and the filter output, both unsigned DATA_W-bit codes and taken in signed DATA_W+1-bit arithmetic, is strictly greater than the threshold. A difference equal to the threshold does not exceed. The comparison works the same way for samples above and below the filter output, and across the full code range.
- R2: A single exceeding valid sample never produces a fill pulse.
- R3: When two consecutive valid samples both exceed, `fill_o` is high for exactly one cycle, in the same cycle as the second sample's valid beat.
- R4: A valid sample that does not exceed clears a pending first exceedance, so exceed, within, exceed gives no fill pulse.
- R5: Cycles with `smp_valid_i` low do not affect detection. Two exceeding valid beats separated only by idle cycles still count as consecutive.
- R6: `refresh_active_o` goes high in the cycle after the fill pulse.
- R7: While refresh is active, `refresh_o` is high on each valid beat and low otherwise. `refresh_active_o` falls in the cycle after the sixth such beat.
- R8: While refresh is active, no fill pulse is produced, whatever the samples are.
- R9: While reset is asserted and right after it, `fill_o`, `refresh_o` and `refresh_active_o` are low and no exceedance is pending.
- R10: After refresh ends, a new detection needs two new consecutive exceeding valid samples. Exceedances seen during refresh are not carried over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Raw sample valid beat |
| smp_data_i | input | DATA_W | Raw sample code |
| filt_data_i | input | DATA_W | Current filter output code |
| thresh_i | input | DATA_W | Step threshold |
| fill_o | output | 1 | Load every second-stage entry with the newest sample |
| refresh_o | output | 1 | Overwrite the averaging window with the newest sample |
| refresh_active_o | output | 1 | Refresh phase in progress |

## Verification
Two things can fall in the same cycle: a valid beat that would complete a step detection, and a valid beat that belongs to the refresh phase. The bench provokes this by sending pairs of far-off samples during the six refresh beats. It expects `refresh_o` on each of those beats and never `fill_o`. It also sends one exceeding sample during refresh and one just after refresh ends, and expects no fill pulse, which shows that the pending state was not carried across the phase boundary.

// File: rtl/step_pkg.sv
package step_pkg;
  typedef enum logic {
    MODE_TRACK   = 1'b0,
    MODE_REFRESH = 1'b1
  } mode_e;
endpackage

// File: rtl/step_absdiff.sv
module step_absdiff #(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] thr_i,
  output logic              exceed_o
);
  localparam int DIFF_W = DATA_W + 1;

  logic signed [DIFF_W-1:0] diff;
  logic        [DIFF_W-1:0] mag;

  always_comb begin
    diff = $signed({1'b0, smp_i}) - $signed({1'b0, ref_i});
    mag  = diff[DIFF_W-1] ? DIFF_W'(-diff) : DIFF_W'(diff);
    exceed_o = mag > {1'b0, thr_i};
  end
endmodule

// File: rtl/step_glitch.sv
module step_glitch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic exceed_i,
  input  logic inhibit_i,
  output logic fill_o
);
  logic pending_q;

  assign fill_o = valid_i & exceed_i & pending_q & ~inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pending_q <= 1'b0;
    else if (inhibit_i) pending_q <= 1'b0;
    else if (valid_i)   pending_q <= exceed_i & ~pending_q;
  end

  // pending never survives a refresh phase
  p_pend_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !pending_q);
  // an idle cycle keeps the pending state
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !inhibit_i) |=> $stable(pending_q));
endmodule

// File: rtl/step_refresh_seq.sv
module step_refresh_seq
  import step_pkg::*;
#(
  parameter int CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  output logic active_o,
  output logic refresh_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q;

  assign active_o  = (mode_q == MODE_REFRESH);
  assign refresh_o = active_o & valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_TRACK;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_TRACK: if (start_i) begin
          mode_q <= MODE_REFRESH;
          cnt_q  <= '0;
        end
        MODE_REFRESH: if (valid_i) begin
          if (cnt_q == LAST) begin
            mode_q <= MODE_TRACK;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: mode_q <= MODE_TRACK;
      endcase
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_end_on_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(refresh_o));
endmodule

// File: rtl/step_detect.sv
module step_detect #(
  parameter int DATA_W     = 24,
  parameter int REFRESH_N  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [DATA_W-1:0] filt_data_i,
  input  logic [DATA_W-1:0] thresh_i,
  output logic              fill_o,
  output logic              refresh_o,
  output logic              refresh_active_o
);
  logic exceed;

  step_absdiff #(.DATA_W(DATA_W)) u_diff (
    .smp_i    (smp_data_i),
    .ref_i    (filt_data_i),
    .thr_i    (thresh_i),
    .exceed_o (exceed)
  );

  step_glitch u_glitch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (smp_valid_i),
    .exceed_i  (exceed),
    .inhibit_i (refresh_active_o),
    .fill_o    (fill_o)
  );

  step_refresh_seq #(.CYCLES(REFRESH_N)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (fill_o),
    .valid_i   (smp_valid_i),
    .active_o  (refresh_active_o),
    .refresh_o (refresh_o)
  );

  p_fill_starts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |=> refresh_active_o);
  p_no_fill_in_refresh_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_active_o |-> !fill_o);
  p_fill_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |=> !fill_o);
  p_fill_on_beat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |-> smp_valid_i);
endmodule

// File: tb/sim_step_detect.sv
module sim_step_detect;
  localparam int W = 24;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         smp_valid_i = 1'b0;
  logic [W-1:0] smp_data_i = '0;
  logic [W-1:0] filt_data_i = '0;
  logic [W-1:0] thresh_i = '0;
  logic         fill_o, refresh_o, refresh_active_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  step_detect #(.DATA_W(W), .REFRESH_N(6)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check outputs, pass the rising edge
  task automatic beat(input logic v, input logic [W-1:0] d,
                      input logic e_fill, input logic e_ref, input logic e_act,
                      input string req);
    @(negedge clk_i);
    smp_valid_i = v;
    smp_data_i  = d;
    #1;
    chk({req, " fill"},   fill_o,           e_fill);
    chk({req, " refresh"}, refresh_o,        e_ref);
    chk({req, " active"}, refresh_active_o, e_act);
    @(posedge clk_i);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 6; i++) beat(1'b1, filt_data_i, 1'b0, 1'b1, 1'b1, req);
    beat(1'b0, '0, 1'b0, 1'b0, 1'b0, {req, " end"});
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R9 fill", fill_o, 1'b0);
    chk("R9 refresh", refresh_o, 1'b0);
    chk("R9 active", refresh_active_o, 1'b0);
    rst_ni = 1'b1;
    // one exceedance after reset must not complete a step alone
    filt_data_i = 24'd1000; thresh_i = 24'd10;
    beat(1'b1, 24'd5000, 1'b0, 1'b0, 1'b0, "R9 post");
    beat(1'b1, 24'd1000, 1'b0, 1'b0, 1'b0, "R9 clr");
  endtask

  task automatic t_threshold();
    beat(1'b1, 24'd1010, 1'b0, 1'b0, 1'b0, "R1 eq+");
    beat(1'b1, 24'd990,  1'b0, 1'b0, 1'b0, "R1 eq-");
    beat(1'b1, 24'd1011, 1'b0, 1'b0, 1'b0, "R2 first");
    beat(1'b1, 24'd989,  1'b1, 1'b0, 1'b0, "R3 second");
    beat(1'b0, 24'd0,    1'b0, 1'b0, 1'b1, "R6 active");
    drain("R7 drain");
  endtask

  task automatic t_refresh_overlap();
    beat(1'b1, 24'd9000, 1'b0, 1'b0, 1'b0, "R2 a");
    beat(1'b1, 24'd9000, 1'b1, 1'b0, 1'b0, "R3 b");
    for (int i = 0; i < 6; i++) begin
      beat(1'b0, 24'd9000, 1'b0, 1'b0, 1'b1, "R7 idle");
      beat(1'b1, 24'd9000, 1'b0, 1'b1, 1'b1, "R8 overlap");
    end
    beat(1'b1, 24'd9000, 1'b0, 1'b0, 1'b0, "R10 first after");
    beat(1'b1, 24'd9000, 1'b1, 1'b0, 1'b0, "R10 second after");
    drain("R7 drain2");
  endtask

  task automatic t_glitch();
    beat(1'b1, 24'd2000, 1'b0, 1'b0, 1'b0, "R4 x");
    beat(1'b1, 24'd1005, 1'b0, 1'b0, 1'b0, "R4 in");
    beat(1'b1, 24'd2000, 1'b0, 1'b0, 1'b0, "R4 x2");
    beat(1'b1, 24'd1000, 1'b0, 1'b0, 1'b0, "R4 in2");
  endtask

  task automatic t_gaps();
    beat(1'b1, 24'd100, 1'b0, 1'b0, 1'b0, "R5 x");
    beat(1'b0, 24'd1000, 1'b0, 1'b0, 1'b0, "R5 gap");
    beat(1'b0, 24'd1000, 1'b0, 1'b0, 1'b0, "R5 gap");
    beat(1'b1, 24'd100, 1'b1, 1'b0, 1'b0, "R5 fill");
    drain("R7 drain3");
  endtask

  task automatic t_extremes();
    filt_data_i = '0; thresh_i = 24'hFFFFFE;
    beat(1'b1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, "R1 top a");
    beat(1'b1, 24'hFFFFFF, 1'b1, 1'b0, 1'b0, "R1 top b");
    drain("R7 drain4");
    filt_data_i = 24'hFFFFFF; thresh_i = 24'hFFFFFF;
    beat(1'b1, 24'h0, 1'b0, 1'b0, 1'b0, "R1 full eq a");
    beat(1'b1, 24'h0, 1'b0, 1'b0, 1'b0, "R1 full eq b");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    t_threshold();
    t_refresh_overlap();
    t_glitch();
    t_gaps();
    t_extremes();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule